// File: doc/BRIEF.md
# Paged Program Counter Sequencer

This block produces the instruction fetch address for a small accumulator-style processor. It keeps a program counter and a small circular stack of return addresses. Each cycle, a decoded operation tells it what to do. It can step to the next word, jump to a subroutine, return from a subroutine, or test a condition and skip one word. The decoder, the register file and interrupt handling sit outside the block.

A subroutine jump does not take its whole target address from the instruction. The low bits come from the instruction's immediate field. The two high bits come from a separate page latch register, which the surrounding core supplies. Calls, returns and taken skips each cost a second cycle. That cycle is signalled by a one-cycle flush output. During the flush cycle the block ignores all operation strobes, so the word fetched in that cycle never takes effect.

After a call or a return, the counter holds its value through the flush cycle so that the target word is fetched. After a taken skip, the counter steps once more during the flush cycle, past the word that is being discarded.

Top module: `pcs_seq`

## Requirements
- R1: A synchronous reset sets the fetch address to 0, clears the flush output and empties the return stack, so the stack pointer is 0.
- R2: With only the next strobe, the fetch address rises by one each cycle and wraps from 8191 to 0 (13-bit counter). With no strobe at all, the fetch address holds.
- R3: A call sets fetch address bits 10:0 to the 11-bit immediate and bits 12:11 to page latch bits 4:3.
- R4: A call pushes the fetch address plus one onto the return stack. A return loads all 13 counter bits from the most recent entry and removes that entry.
- R5: In the cycle after a call or a return, flush is 1 for exactly one cycle. During that cycle all strobes are ignored and the fetch address holds.
- R6: A skip with the condition flag at 1 advances the fetch address by one and raises flush for one cycle. During that flush cycle all strobes are ignored and the address advances by one more.
- R7: A skip with the condition flag at 0 advances the fetch address by one and leaves flush at 0.
- R8: The return stack holds 8 entries in a circle. A ninth push overwrites the oldest entry, and pops then wrap around the same circle.
- R9: When several strobes are high in the same cycle, call wins over return, return wins over skip, and skip wins over next.
- R10: Page latch bits other than 4:3 have no effect on the call target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_next | input | 1 | Step to the next word |
| op_call | input | 1 | Subroutine call |
| op_ret | input | 1 | Return from subroutine |
| op_skip | input | 1 | Conditional skip of the next word |
| imm | input | 11 | Call target, low address bits |
| page_latch | input | 8 | Page latch register; bits 4:3 give the high address bits |
| skip_cond | input | 1 | Skip condition, sampled with op_skip |
| fetch_addr | output | 13 | Current fetch address |
| flush | output | 1 | High in the second cycle of a call, return or taken skip |

## Verification
The bench targets several corner cases, and each has a clear failure if the design gets it wrong:
- Counter wrap: a call to the top address followed by a step must reach 0. A counter that saturates would stay at 8191.
- Strobes during flush: calls and returns are offered during flush cycles. A design that acted on them would jump, or corrupt the stack.
- Step versus hold after a flush: after a taken skip the address must step once more, and after a call it must hold. A design that mixes these up would run the skipped word or skip the call target.
- Stack overflow: the bench pushes nine entries and then pops nine. A stack that saturated instead of wrapping would return the wrong addresses on the last pops.
- Strobe priority: all strobes are raised together. A design with the wrong priority would push nothing or jump to the wrong address.
- Page latch: bits other than 4:3 are set during a call. A design that used them would produce a bad target.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

   typedef enum logic [1:0] {
      FK_NONE = 2'd0,
      FK_HOLD = 2'd1,
      FK_STEP = 2'd2
   } flush_kind_e;

   typedef struct packed {
      logic call;
      logic ret;
      logic skip;
      logic step;
   } op_bundle_t;

endpackage

// File: rtl/pcs_stack.sv
module pcs_stack #(
   parameter int DEPTH = 8,
   parameter int WIDTH = 13
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             push,
   input  logic             pop,
   input  logic [WIDTH-1:0] push_data,
   output logic [WIDTH-1:0] top
);
   localparam int PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit IS_POW2  = (DEPTH == (1 << PTR_W));

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("pcs_stack: DEPTH must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("pcs_stack: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] ptr;
   logic [PTR_W-1:0] ptr_inc;
   logic [PTR_W-1:0] ptr_dec;

   generate
      if (IS_POW2) begin : g_wrap_free
         always_comb begin
            ptr_inc = ptr + 1'b1;
            ptr_dec = ptr - 1'b1;
         end
      end else begin : g_wrap_cmp
         localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
         always_comb begin
            ptr_inc = (ptr == LAST) ? '0 : ptr + 1'b1;
            ptr_dec = (ptr == '0) ? LAST : ptr - 1'b1;
         end
      end
   endgenerate

   assign top = mem[ptr_dec];

   always_ff @(posedge clk) begin
      if (rst) begin
         ptr <= '0;
      end else if (push) begin
         mem[ptr] <= push_data;
         ptr      <= ptr_inc;
      end else if (pop) begin
         ptr <= ptr_dec;
      end
   end

   AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(push && pop));                                                   // R9
   AST_PUSH_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      push |=> top == $past(push_data));                                 // R4
   AST_POP_RETREAT: assert property (@(posedge clk) disable iff (rst)
      pop |=> ptr_inc == $past(ptr));                                    // R8

endmodule

// File: rtl/pcs_next.sv
module pcs_next
   import pcs_pkg::*;
#(
   parameter int PC_W    = 13,
   parameter int IMM_W   = 11,
   parameter int PAGE_W  = 8,
   parameter int PAGE_LO = 3
) (
   input  logic [PC_W-1:0]   pc,
   input  flush_kind_e       kind,
   input  op_bundle_t        ops,
   input  logic              skip_cond,
   input  logic [IMM_W-1:0]  imm,
   input  logic [PAGE_W-1:0] page_latch,
   input  logic [PC_W-1:0]   stack_top,
   output logic [PC_W-1:0]   pc_nxt,
   output flush_kind_e       kind_nxt,
   output logic              push,
   output logic              pop,
   output logic [PC_W-1:0]   ret_addr
);
   localparam int PG_W = PC_W - IMM_W;

   logic [PC_W-1:0] pc_plus1;
   logic [PC_W-1:0] call_tgt;

   assign pc_plus1 = pc + 1'b1;
   assign ret_addr = pc_plus1;

   generate
      if (PG_W > 0) begin : g_paged
         assign call_tgt = {page_latch[PAGE_LO +: PG_W], imm};
      end else begin : g_flat
         assign call_tgt = imm[PC_W-1:0];
      end
   endgenerate

   always_comb begin
      pc_nxt   = pc;
      kind_nxt = FK_NONE;
      push     = 1'b0;
      pop      = 1'b0;
      unique case (kind)
         FK_HOLD: pc_nxt = pc;
         FK_STEP: pc_nxt = pc_plus1;
         default: begin
            if (ops.call) begin
               pc_nxt   = call_tgt;
               push     = 1'b1;
               kind_nxt = FK_HOLD;
            end else if (ops.ret) begin
               pc_nxt   = stack_top;
               pop      = 1'b1;
               kind_nxt = FK_HOLD;
            end else if (ops.skip) begin
               pc_nxt   = pc_plus1;
               kind_nxt = skip_cond ? FK_STEP : FK_NONE;
            end else if (ops.step) begin
               pc_nxt = pc_plus1;
            end
         end
      endcase
   end

endmodule

// File: rtl/pcs_seq.sv
module pcs_seq
   import pcs_pkg::*;
#(
   parameter int PC_W        = 13,
   parameter int IMM_W       = 11,
   parameter int PAGE_W      = 8,
   parameter int PAGE_LO     = 3,
   parameter int STACK_DEPTH = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              op_next,
   input  logic              op_call,
   input  logic              op_ret,
   input  logic              op_skip,
   input  logic [IMM_W-1:0]  imm,
   input  logic [PAGE_W-1:0] page_latch,
   input  logic              skip_cond,
   output logic [PC_W-1:0]   fetch_addr,
   output logic              flush
);
   localparam int PG_W = PC_W - IMM_W;

   generate
      if (PG_W < 0) begin : g_bad_imm
         $error("pcs_seq: IMM_W must not exceed PC_W");
      end
      if (PAGE_LO + PG_W > PAGE_W) begin : g_bad_page
         $error("pcs_seq: page field lies outside the page latch");
      end
   endgenerate

   logic [PC_W-1:0] pc_q;
   logic [PC_W-1:0] pc_nxt;
   logic [PC_W-1:0] stack_top;
   logic [PC_W-1:0] ret_addr;
   flush_kind_e     kind_q;
   flush_kind_e     kind_nxt;
   op_bundle_t      ops;
   logic            push;
   logic            pop;

   assign ops = '{call: op_call, ret: op_ret, skip: op_skip, step: op_next};

   pcs_next #(
      .PC_W(PC_W), .IMM_W(IMM_W), .PAGE_W(PAGE_W), .PAGE_LO(PAGE_LO)
   ) next_i (
      .pc(pc_q), .kind(kind_q), .ops(ops), .skip_cond(skip_cond),
      .imm(imm), .page_latch(page_latch), .stack_top(stack_top),
      .pc_nxt(pc_nxt), .kind_nxt(kind_nxt), .push(push), .pop(pop),
      .ret_addr(ret_addr)
   );

   pcs_stack #(
      .DEPTH(STACK_DEPTH), .WIDTH(PC_W)
   ) stack_i (
      .clk(clk), .rst(rst), .push(push), .pop(pop),
      .push_data(ret_addr), .top(stack_top)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q   <= '0;
         kind_q <= FK_NONE;
      end else begin
         pc_q   <= pc_nxt;
         kind_q <= kind_nxt;
      end
   end

   assign fetch_addr = pc_q;
   assign flush      = (kind_q != FK_NONE);

   AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (rst)
      flush |=> !flush);                                                 // R5
   AST_CALL_TARGET: assert property (@(posedge clk) disable iff (rst)
      (op_call && !flush) |=> flush &&
         fetch_addr[IMM_W-1:0] == $past(imm));                           // R3
   AST_RET_TARGET: assert property (@(posedge clk) disable iff (rst)
      (op_ret && !op_call && !flush) |=>
         flush && fetch_addr == $past(stack_top));                       // R4
   AST_SKIP_TAKEN: assert property (@(posedge clk) disable iff (rst)
      (op_skip && skip_cond && !op_call && !op_ret && !flush) |=>
         flush && fetch_addr == $past(fetch_addr) + 1'b1);               // R6
   AST_SKIP_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
      (op_skip && !skip_cond && !op_call && !op_ret && !flush) |=>
         !flush);                                                        // R7
   AST_FLUSH_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
      flush |-> !push && !pop);                                          // R5

endmodule

// File: tb/pcs_seq_tb.sv
`timescale 1ns/1ps
module pcs_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst;
   logic        op_next, op_call, op_ret, op_skip, skip_cond;
   logic [10:0] imm;
   logic [7:0]  page_latch;
   logic [12:0] fetch_addr;
   logic        flush;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   pcs_seq dut_i (
      .clk(clk), .rst(rst), .op_next(op_next), .op_call(op_call),
      .op_ret(op_ret), .op_skip(op_skip), .imm(imm),
      .page_latch(page_latch), .skip_cond(skip_cond),
      .fetch_addr(fetch_addr), .flush(flush)
   );

   // {ops = call,ret,skip,next (4), imm (11), page (8), cond (1), exp addr (13), exp flush (1)}
   localparam int NV = 22;
   localparam logic [37:0] VEC [NV] = '{
      {4'b0001, 11'h000, 8'h00, 1'b0, 13'h0001, 1'b0},  // R2 step
      {4'b0001, 11'h000, 8'h00, 1'b0, 13'h0002, 1'b0},  // R2 step
      {4'b0000, 11'h000, 8'h00, 1'b0, 13'h0002, 1'b0},  // R2 idle holds
      {4'b0010, 11'h000, 8'h00, 1'b0, 13'h0003, 1'b0},  // R7 skip not taken
      {4'b0010, 11'h000, 8'h00, 1'b1, 13'h0004, 1'b1},  // R6 skip taken
      {4'b1001, 11'h155, 8'h00, 1'b0, 13'h0005, 1'b0},  // R6 flush steps, call ignored
      {4'b1000, 11'h123, 8'h08, 1'b0, 13'h0923, 1'b1},  // R3 call, page 01
      {4'b0100, 11'h000, 8'h00, 1'b0, 13'h0923, 1'b0},  // R5 hold, ret ignored
      {4'b0001, 11'h000, 8'h00, 1'b0, 13'h0924, 1'b0},  // R2
      {4'b1000, 11'h7FF, 8'hFF, 1'b0, 13'h1FFF, 1'b1},  // R10 other page bits set
      {4'b0001, 11'h000, 8'h00, 1'b0, 13'h1FFF, 1'b0},  // R5 hold
      {4'b0001, 11'h000, 8'h00, 1'b0, 13'h0000, 1'b0},  // R2 wrap
      {4'b0100, 11'h000, 8'h00, 1'b0, 13'h0925, 1'b1},  // R4 return
      {4'b0001, 11'h000, 8'h00, 1'b0, 13'h0925, 1'b0},  // R5 hold
      {4'b0100, 11'h000, 8'h00, 1'b0, 13'h0006, 1'b1},  // R4 return
      {4'b0000, 11'h000, 8'h00, 1'b0, 13'h0006, 1'b0},  // R5
      {4'b1111, 11'h010, 8'h00, 1'b1, 13'h0010, 1'b1},  // R9 call wins
      {4'b0000, 11'h000, 8'h00, 1'b0, 13'h0010, 1'b0},  // R5
      {4'b0111, 11'h000, 8'h00, 1'b1, 13'h0007, 1'b1},  // R9 return wins
      {4'b0000, 11'h000, 8'h00, 1'b0, 13'h0007, 1'b0},  // R5
      {4'b0011, 11'h000, 8'h00, 1'b1, 13'h0008, 1'b1},  // R9 skip wins
      {4'b0000, 11'h000, 8'h00, 1'b0, 13'h0009, 1'b0}   // R6 flush steps
   };

   task automatic check(input string tag, input logic [12:0] ea, input logic ef);
      checks++;
      if (fetch_addr !== ea || flush !== ef) begin
         errors++;
         $display("FAIL %s: addr=%h flush=%b expected addr=%h flush=%b",
                  tag, fetch_addr, flush, ea, ef);
      end
   endtask

   task automatic drive(input logic [3:0] ops, input logic [10:0] im,
                        input logic [7:0] pg, input logic cond);
      {op_call, op_ret, op_skip, op_next} = ops;
      imm = im; page_latch = pg; skip_cond = cond;
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      drive(4'b0000, '0, '0, 1'b0);
      drive(4'b0000, '0, '0, 1'b0);
      rst = 1'b0;
   endtask

   initial begin
      logic [12:0] pushed [9];
      do_reset();
      check("R1 reset state", 13'h0000, 1'b0);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][37:34], VEC[i][33:23], VEC[i][22:15], VEC[i][14]);
         check($sformatf("R2-R10 vector %0d", i), VEC[i][13:1], VEC[i][0]);
      end

      // R1: reset mid-run returns to zero
      do_reset();
      check("R1 reset after activity", 13'h0000, 1'b0);

      // R8: nine calls then nine returns on an 8-entry circular stack
      for (int k = 1; k <= 9; k++) begin
         pushed[k-1] = 13'((k - 1) * 16 + 1);
         drive(4'b1000, 11'(k * 16), 8'h00, 1'b0);
         check("R8 call", 13'(k * 16), 1'b1);
         drive(4'b0000, '0, '0, 1'b0);
      end
      for (int k = 8; k >= 1; k--) begin
         drive(4'b0100, '0, '0, 1'b0);
         check("R8 return", pushed[k], 1'b1);
         drive(4'b0000, '0, '0, 1'b0);
         check("R5 hold after return", pushed[k], 1'b0);
      end
      drive(4'b0100, '0, '0, 1'b0);
      check("R8 wrapped return", pushed[8], 1'b1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: addr=%h flush=%b expected completion", fetch_addr, flush);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule